// File: doc/BRIEF.md
# Serial-Controlled Six-Channel Half-Bridge Controller

This block is the digital core of a six-channel half-bridge power driver. A host sends it a 16-bit command over a three-wire serial link: an active-low select, a serial clock and a data line. In the same transfer the block shifts a 16-bit status word back out. The command decides which high-side and low-side gate enables are on. It also sets the open-load detection mode and the short-circuit shutdown delay, and it can clear latched short-circuit faults.

The serial inputs are asynchronous to the system clock. They pass through two-stage synchronizers, and edges are then detected in the system clock domain. Each bridge has an overcurrent flag input. When that flag stays high for the selected delay, the bridge is shut off and a sticky fault flag is set. The fault holds until a command carrying the status-reset bit arrives. Outputs are also forced off by a software standby bit or by an external inhibit pin, and the serial link keeps working in both cases.

Top module: `hbridge_ctrl`

## Requirements
- R1: A command is shifted in least-significant bit first, one bit per `sclk` rising edge while `sel_n` is low. It takes effect only at the `sel_n` rising edge, and only if exactly 16 `sclk` rising edges occurred. A frame of any other length leaves every output and setting unchanged.
- R2: At the `sel_n` falling edge the status word is captured. It appears on `sdo` least-significant bit first and advances on each `sclk` falling edge. `sdo_oe` is high only while the select is low.
- R3: Command bits [5:0] enable the high sides of bridges 0..5, and bits [11:6] enable the low sides of the same bridges.
- R4: A bridge whose high-side and low-side bits are both set in the command drives neither side.
- R5: Command bit 15 is the run bit. While it is 0, all twelve enables are off, yet transfers, status read-out and command updates still work.
- R6: While `inh` is low, all enables are off. They return to the commanded state when `inh` goes high again, provided the run bit is 1.
- R7: Command bit 14 disables open-load detection when 1. `ol_det_en` equals its inverse, and the open-load status bits read 0 while detection is off.
- R8: Command bit 13 selects the shutdown delay. When it is 1, the delay is 12 ms, or 12*CYC_PER_MS clock cycles. When it is 0, the delay is 1.5 ms, or 3*CYC_PER_MS/2 cycles. `sc_long` mirrors the bit. A bridge trips once its `oc_flag` has been high for that many consecutive cycles, and the count restarts whenever the flag drops.
- R9: A tripped bridge drives neither side, and status bit 13 stays set until a valid command with bit 12 set arrives. That command clears every trip and re-enables the affected bridges.
- R10: Status layout:
  - [5:0]: a bridge drives either side.
  - [11:6]: open-load flags.
  - [12]: the `temp_warn` input.
  - [13]: short-circuit latched.
  - [14]: outputs are held off by standby or by `inh`.
  - [15]: always 0.
- R11: After reset:
  - all enables are off;
  - `sdo_oe` is 0;
  - `ol_det_en` is 1;
  - `sc_long` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| sel_n | input | 1 | Serial select, active low |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial status data |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| inh | input | 1 | External inhibit, high = operate |
| oc_flag | input | 6 | Per-bridge overcurrent flag |
| ol_flag | input | 6 | Per-bridge open-load flag |
| temp_warn | input | 1 | Temperature prewarning |
| hs_en | output | 6 | High-side gate enables |
| ls_en | output | 6 | Low-side gate enables |
| ol_det_en | output | 1 | Open-load detection enable |
| sc_long | output | 1 | Long shutdown delay selected |

## Verification
The assertions assume that `oc_flag` is synchronous to `clk`. They also assume that serial edges are spaced several system clocks apart, so that the synchronizers see every level.

The stimulus keeps each serial half-period at eight clocks and keeps `sdi` stable across each `sclk` rise. It changes `inh`, `ol_flag` and `temp_warn` only between frames, and it drives `oc_flag` only on the falling edge of `clk`.

// File: rtl/hbc_pkg.sv
// Shared constants for the half-bridge controller: word width, channel
// count and the bit positions that the command and status words use.
package hbc_pkg;
    localparam int WORD_W    = 16;
    localparam int NCH       = 6;
    // command word fields
    localparam int CMD_LS0   = 6;
    localparam int CMD_RST   = 12;
    localparam int CMD_LONG  = 13;
    localparam int CMD_OLOFF = 14;
    localparam int CMD_RUN   = 15;
    // status word fields
    localparam int ST_OL0    = 6;
    localparam int ST_TEMP   = 12;
    localparam int ST_SC     = 13;
    localparam int ST_STBY   = 14;
endpackage

// File: rtl/hbc_serial.sv
// Serial front end. It synchronizes select, clock and data into clk,
// shifts commands in LSB first on sclk rise, and shifts the status out
// LSB first on sclk fall. It pulses word_vld at the select rise when
// exactly W bits were received.
// Assumes serial edges are several clk periods apart.
module hbc_serial #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_i,
    input  logic         sel_n_i,
    input  logic         sdi_i,
    input  logic [W-1:0] status_i,
    output logic         sdo_o,
    output logic         sdo_oe_o,
    output logic [W-1:0] word_o,
    output logic         word_vld_o
);
    localparam int CW = $clog2(W + 2);

    logic [2:0]    sck_q;
    logic [2:0]    cs_q;
    logic [1:0]    di_q;
    logic [W-1:0]  in_sr;
    logic [W-1:0]  out_sr;
    logic [CW-1:0] bit_cnt;

    logic sck_rise, sck_fall, cs_fall, cs_rise, sel;

    // Synchronizer and edge-history registers for the serial pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= '1;
            di_q  <= '0;
        end else begin
            sck_q <= {sck_q[1:0], sclk_i};
            cs_q  <= {cs_q[1:0], sel_n_i};
            di_q  <= {di_q[0], sdi_i};
        end
    end

    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];
    assign cs_fall  = ~cs_q[1] & cs_q[2];
    assign cs_rise  = cs_q[1] & ~cs_q[2];
    assign sel      = ~cs_q[1];

    // Shift registers and the bit counter for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr   <= '0;
            out_sr  <= '0;
            bit_cnt <= '0;
        end else if (cs_fall) begin
            out_sr  <= status_i;
            bit_cnt <= '0;
        end else begin
            if (sel && sck_rise) begin
                in_sr <= {di_q[1], in_sr[W-1:1]};
                if (bit_cnt != CW'(W + 1))
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (sel && sck_fall)
                out_sr <= {1'b0, out_sr[W-1:1]};
        end
    end

    // Frame-complete strobe at the end of the select.
    always_ff @(posedge clk) begin
        if (!rst_n) word_vld_o <= 1'b0;
        else        word_vld_o <= cs_rise && (bit_cnt == CW'(W));
    end

    assign word_o   = in_sr;
    assign sdo_o    = out_sr[0];
    assign sdo_oe_o = sel;
endmodule

// File: rtl/hbc_sc_timer.sv
// Per-bridge short-circuit timers. A bridge trips after its overcurrent
// flag stays high for lim_m1+1 consecutive cycles. The count restarts
// when the flag drops, and a trip holds until clr.
// Assumes oc is synchronous to clk.
module hbc_sc_timer #(
    parameter int NCH   = 6,
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   oc,
    input  logic [CNT_W-1:0] lim_m1,
    input  logic             clr,
    output logic [NCH-1:0]   dis
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CNT_W-1:0] cnt;

        // Persistence counter and trip latch for one bridge.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cnt    <= '0;
                dis[g] <= 1'b0;
            end else if (dis[g] || !oc[g]) begin
                cnt <= '0;
            end else if (cnt >= lim_m1) begin
                cnt    <= '0;
                dis[g] <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hbridge_ctrl.sv
// Top of the half-bridge controller. It holds the applied command, gates
// the enables by shoot-through, trip, standby and the inhibit pin, and
// assembles the status word.
// Assumes CYC_PER_MS clock cycles per millisecond.
module hbridge_ctrl
    import hbc_pkg::*;
#(
    parameter int CYC_PER_MS = 10000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sel_n,
    input  logic           sdi,
    output logic           sdo,
    output logic           sdo_oe,
    input  logic           inh,
    input  logic [NCH-1:0] oc_flag,
    input  logic [NCH-1:0] ol_flag,
    input  logic           temp_warn,
    output logic [NCH-1:0] hs_en,
    output logic [NCH-1:0] ls_en,
    output logic           ol_det_en,
    output logic           sc_long
);
    localparam int LONG_CYC  = 12 * CYC_PER_MS;
    localparam int SHORT_CYC = (3 * CYC_PER_MS) / 2;
    localparam int CNT_W     = $clog2(LONG_CYC + 1);

    logic [WORD_W-1:0] word, cmd, status;
    logic              word_vld, word_rst, run, sc_flag;
    logic [NCH-1:0]    dis, hs_cmd, ls_cmd;
    logic [CNT_W-1:0]  lim_m1;

    hbc_serial #(.W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdi),
        .status_i(status), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .word_o(word), .word_vld_o(word_vld)
    );

    // Applied command register, loaded only on a complete frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd <= '0;
        else if (word_vld) cmd <= word & ~(WORD_W'(1) << CMD_RST);
    end

    assign word_rst = word_vld & word[CMD_RST];
    assign lim_m1   = cmd[CMD_LONG] ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);

    hbc_sc_timer #(.NCH(NCH), .CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .oc(oc_flag), .lim_m1(lim_m1),
        .clr(word_rst), .dis(dis)
    );

    // Gate the enables and assemble the status word.
    always_comb begin
        hs_cmd = cmd[NCH-1:0];
        ls_cmd = cmd[CMD_LS0 +: NCH];
        run    = cmd[CMD_RUN] & inh;
        hs_en  = run ? (hs_cmd & ~ls_cmd & ~dis) : '0;
        ls_en  = run ? (ls_cmd & ~hs_cmd & ~dis) : '0;
        sc_flag = |dis;
        status = '0;
        status[NCH-1:0]       = hs_en | ls_en;
        status[ST_OL0 +: NCH] = cmd[CMD_OLOFF] ? '0 : ol_flag;
        status[ST_TEMP]       = temp_warn;
        status[ST_SC]         = sc_flag;
        status[ST_STBY]       = ~run;
    end

    assign ol_det_en = ~cmd[CMD_OLOFF];
    assign sc_long   = cmd[CMD_LONG];
endmodule

// File: rtl/hbc_checker.sv
// Property checker for hbridge_ctrl, attached with bind below.
// Assumes oc_flag is synchronous to clk.
module hbc_checker #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           inh,
    input logic [NCH-1:0] oc_flag,
    input logic [NCH-1:0] hs_en,
    input logic [NCH-1:0] ls_en,
    input logic           ol_det_en,
    input logic           sc_long,
    input logic           word_vld,
    input logic           word_rst,
    input logic           sc_flag
);
    assert_no_shoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == '0);

    assert_pin_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inh |-> ((hs_en | ls_en) == '0));

    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(sc_long) && $stable(ol_det_en)));

    assert_trip_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_flag) |-> $past(|oc_flag));

    assert_trip_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_flag && !word_rst) |=> sc_flag);
endmodule

bind hbridge_ctrl hbc_checker #(.NCH(hbc_pkg::NCH)) i_chk (
    .clk(clk), .rst_n(rst_n), .inh(inh), .oc_flag(oc_flag),
    .hs_en(hs_en), .ls_en(ls_en), .ol_det_en(ol_det_en), .sc_long(sc_long),
    .word_vld(word_vld), .word_rst(word_rst), .sc_flag(sc_flag)
);

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;
    localparam int CPM   = 8;
    localparam int SHORT = (3 * CPM) / 2;
    localparam int LONG  = 12 * CPM;

    logic clk = 1'b0;
    logic rst_n, sclk, sel_n, sdi, sdo, sdo_oe, inh, temp_warn, ol_det_en, sc_long;
    logic [5:0] oc_flag, ol_flag, hs_en, ls_en;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_cmd;
    logic [5:0]  m_dis;

    always #2 clk = ~clk;

    hbridge_ctrl #(.CYC_PER_MS(CPM)) i_hbridge_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .inh(inh), .oc_flag(oc_flag),
        .ol_flag(ol_flag), .temp_warn(temp_warn), .hs_en(hs_en), .ls_en(ls_en),
        .ol_det_en(ol_det_en), .sc_long(sc_long)
    );

    function automatic logic [5:0] exp_hs();
        return (m_cmd[15] && inh) ? (m_cmd[5:0] & ~m_cmd[11:6] & ~m_dis) : 6'h0;
    endfunction

    function automatic logic [5:0] exp_ls();
        return (m_cmd[15] && inh) ? (m_cmd[11:6] & ~m_cmd[5:0] & ~m_dis) : 6'h0;
    endfunction

    function automatic logic [15:0] exp_status();
        logic run;
        run = m_cmd[15] && inh;
        return {1'b0, ~run, |m_dis, temp_warn,
                (m_cmd[14] ? 6'h0 : ol_flag), exp_hs() | exp_ls()};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nclk bits. Returns the bits read on sdo.
    task automatic xfer(input logic [15:0] w, input int nclk, output logic [15:0] rd);
        rd = '0;
        sel_n = 1'b0;
        wclk(8);
        for (int i = 0; i < nclk; i++) begin
            sdi = w[i % 16];
            wclk(4);
            if (i < 16) rd[i] = sdo;
            chk("R2 oe", {15'h0, sdo_oe}, 16'h1);
            sclk = 1'b1;
            wclk(8);
            sclk = 1'b0;
            wclk(4);
        end
        wclk(8);
        sel_n = 1'b1;
        wclk(10);
    endtask

    // Full transfer, with the status and output checks and the model update.
    task automatic cmd_xfer(input logic [15:0] w, input string req);
        logic [15:0] rd, st;
        st = exp_status();
        xfer(w, 16, rd);
        chk({req, " R2 R10 status"}, rd, st);
        if (w[12]) m_dis = '0;
        m_cmd = w & 16'hEFFF;
        chk({req, " R3 hs"}, {10'h0, hs_en}, {10'h0, exp_hs()});
        chk({req, " R3 ls"}, {10'h0, ls_en}, {10'h0, exp_ls()});
        chk({req, " R7 ol_det_en"}, {15'h0, ol_det_en}, {15'h0, ~m_cmd[14]});
        chk({req, " R8 sc_long"}, {15'h0, sc_long}, {15'h0, m_cmd[13]});
    endtask

    task automatic pulse_oc(input int ch, input int n);
        oc_flag[ch] = 1'b1;
        wclk(n);
        oc_flag[ch] = 1'b0;
        wclk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rd, w;
        void'($urandom(32'd4242));
        rst_n = 1'b0; sclk = 1'b0; sel_n = 1'b1; sdi = 1'b0; inh = 1'b1;
        oc_flag = '0; ol_flag = '0; temp_warn = 1'b0;
        m_cmd = '0; m_dis = '0;
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        // R11: state after reset
        chk("R11 hs", {10'h0, hs_en}, 16'h0);
        chk("R11 ls", {10'h0, ls_en}, 16'h0);
        chk("R11 oe", {15'h0, sdo_oe}, 16'h0);
        chk("R11 ol_det_en", {15'h0, ol_det_en}, 16'h1);
        chk("R11 sc_long", {15'h0, sc_long}, 16'h0);

        // R3: high sides of bridges 0..2
        cmd_xfer(16'h8007, "R3 basic");
        // R3: low sides of bridges 3..5
        cmd_xfer(16'h8000 | (16'h38 << 6), "R3 low");
        // R4: bridge 0 has both sides set, bridge 1 high side only
        cmd_xfer(16'h8000 | 16'h0003 | (16'h1 << 6), "R4 shoot");
        chk("R4 bridge0 off", {15'h0, hs_en[0] | ls_en[0]}, 16'h0);

        // R1: frames of 15 and 17 bits are ignored
        xfer(16'h803F, 15, rd);
        chk("R1 short frame", {10'h0, hs_en}, {10'h0, exp_hs()});
        xfer(16'hC03F, 17, rd);
        chk("R1 long frame hs", {10'h0, hs_en}, {10'h0, exp_hs()});
        chk("R1 long frame ol", {15'h0, ol_det_en}, 16'h1);

        // R5: standby still accepts commands and reports status
        cmd_xfer(16'h003F, "R5 standby");
        chk("R5 off", {10'h0, hs_en}, 16'h0);
        ol_flag = 6'h15; temp_warn = 1'b1;
        cmd_xfer(16'h8009, "R5 wake");
        // R6: the inhibit pin forces off, then restores
        inh = 1'b0;
        wclk(2);
        chk("R6 pin off", {10'h0, hs_en}, 16'h0);
        cmd_xfer(16'h8003, "R6 during pin");
        inh = 1'b1;
        wclk(2);
        chk("R6 restore", {10'h0, hs_en}, 16'h3);
        // R7: open-load detection switched off
        cmd_xfer(16'hC004, "R7 ol off");
        cmd_xfer(16'h8004, "R7 ol on");
        ol_flag = '0; temp_warn = 1'b0;

        // R8: short delay; the count restarts when the flag drops
        pulse_oc(2, SHORT - 1);
        pulse_oc(2, SHORT - 1);
        chk("R8 no trip", {10'h0, hs_en}, 16'h4);
        oc_flag[2] = 1'b1;
        wclk(SHORT);
        chk("R8 trip at limit", {10'h0, hs_en}, 16'h0);
        oc_flag[2] = 1'b0;
        m_dis[2] = 1'b1;
        // R9: stays off without the reset bit, clears with it
        cmd_xfer(16'h8004, "R9 sticky");
        chk("R9 still off", {10'h0, hs_en}, 16'h0);
        cmd_xfer(16'h9004, "R9 clear");
        chk("R9 re-enabled", {10'h0, hs_en}, 16'h4);

        // R8: long delay
        cmd_xfer(16'hA020, "R8 long");
        pulse_oc(5, LONG - 1);
        chk("R8 long no trip", {10'h0, hs_en}, 16'h20);
        oc_flag[5] = 1'b1;
        wclk(LONG);
        chk("R8 long trip", {10'h0, hs_en}, 16'h0);
        oc_flag[5] = 1'b0;
        m_dis[5] = 1'b1;
        cmd_xfer(16'hB020, "R9 long clear");

        // random commands and random frame lengths
        for (int k = 0; k < 60; k++) begin
            int nb;
            logic [15:0] st;
            w = 16'($urandom);
            nb = ($urandom % 8 == 0) ? (($urandom % 2 == 0) ? 15 : 17) : 16;
            inh = ($urandom % 8) != 0;
            ol_flag = 6'($urandom);
            temp_warn = 1'($urandom);
            if (nb == 16) begin
                cmd_xfer(w, "R1 R3 random");
            end else begin
                st = exp_status();
                xfer(w, nb, rd);
                chk("R1 R2 partial status", rd & 16'h7FFF, st & 16'h7FFF);
                chk("R1 ignored hs", {10'h0, hs_en}, {10'h0, exp_hs()});
                chk("R1 ignored ls", {10'h0, ls_en}, {10'h0, exp_ls()});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule